// File: doc/BRIEF.md
# Serial Port Bit-Clock and Frame-Pulse Generator

This block derives a bit clock and a periodic frame pulse from the internal input clock of a serial port. The bit clock is the input clock divided by a programmable integer. The frame pulse repeats every programmable number of bit-clock periods and stays high for a programmable number of them. Each output changes on a rising edge of the bit clock.

Two active-high "run" bits, loaded through a single-cycle write port, control the block. One run bit starts or stops the whole generator. The other starts or stops only the frame-pulse logic. A run value of 0 holds that logic in reset. Both bits can be read back at any time.

After a hardware reset the generator is stopped. While it stays stopped for that reason, the bit clock still toggles at half the input rate. Once software has run the generator, stopping it again holds both outputs low.

A new divider or frame setting written while the generator runs takes effect at the next bit-clock period boundary. This avoids a shortened period.

Top module: `srg_clkfs_gen`

## Requirements
- R1: While `rst_n` is low, `bit_clk`, `frame_sync`, `gen_run_rd` and `fs_run_rd` are all 0.
- R2: After hardware reset, and until a write with `wr_gen_run`=1 occurs, `bit_clk` inverts on every rising input edge. The first inversion (to 1) happens on the first edge after `rst_n` rises. A write with `wr_gen_run`=0 does not stop the toggling. `frame_sync` stays 0 even when the frame run bit is 1.
- R3: A write (`wr_en`=1 for one cycle) updates `gen_run_rd` and `fs_run_rd` to the written bits on the edge that samples the write.
- R4: After any write with `wr_gen_run`=1 has been accepted, writing `wr_gen_run`=0 makes `bit_clk` and `frame_sync` 0 in both clock phases from the second edge after the write edge onward.
- R5: The generator is enabled by the write edge E. Let N = `wr_div`+1 and count edges k=0,1,… from the edge after E. For N>1, `bit_clk` after edge k is 1 exactly when k mod N < (N+1)/2 (integer division), so a bit-clock rising edge happens at each k that is a multiple of N. For N=1, `bit_clk` equals the input clock.
- R6: With P=`wr_fper` and W=`wr_fwid`, the frame position advances by one at each bit-clock rising edge and wraps from P to 0. `frame_sync` is 1 while the position is at most W. This gives a period of P+1 bit clocks and a high width of W+1, or a constant high when W≥P.
- R7: When the frame run bit becomes 1 while the generator runs, the position restarts at 0. The first pulse begins at the first bit-clock rising edge strictly after the edge that registered the bit. If both bits are enabled by one write, that is edge k=0.
- R8: Once `fs_run_rd` reads 0, `frame_sync` is 0 from the next edge on, and `bit_clk` continues undisturbed.
- R9: A divider setting written while the generator runs takes effect at the first bit-clock rising edge after the write edge. Until then the old divider continues.
- R10: While the generator runs, `bit_clk` follows R5 whatever the frame run bit is, and `frame_sync` stays 0 while the frame run bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal input clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | One-cycle write strobe for all settings |
| wr_gen_run | input | 1 | Generator run bit (0 = held in reset) |
| wr_fs_run | input | 1 | Frame-pulse run bit (0 = held in reset) |
| wr_div | input | 8 | Divider setting, bit clock = clk/(value+1) |
| wr_fper | input | 12 | Frame period minus one, in bit clocks |
| wr_fwid | input | 8 | Frame pulse width minus one, in bit clocks |
| gen_run_rd | output | 1 | Current generator run bit |
| fs_run_rd | output | 1 | Current frame-pulse run bit |
| bit_clk | output | 1 | Generated bit clock |
| frame_sync | output | 1 | Generated frame pulse |

## Verification
Inputs are driven just after a falling edge, so each write is sampled by the following rising edge E. Both run bits read back right after E.

The divided clock reaches its first rising edge one input edge after E, because of the fresh-start register. The frame pulse changes on those same bit-clock rising edges. A frame-pulse disable shows at the output two edges after the write, since the edge that registers it still updates normally.

The bench numbers edges from the edge after E and computes expected levels arithmetically from N, P and W. It samples every output one time unit after both the rising and the falling edge. This places each sample inside the phase being checked, which also covers the pass-through divider.

// File: rtl/srg_pkg.sv
package srg_pkg;

    // Operating state of the bit-clock path
    typedef enum logic [1:0] {
        CM_HALT = 2'd0,   // stopped by software: output held low
        CM_HALF = 2'd1,   // stopped since hardware reset: toggle every edge
        CM_RUN  = 2'd2    // running from the programmed divider
    } clk_mode_e;

endpackage

// File: rtl/srg_ctrl.sv
module srg_ctrl
    import srg_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int FPER_W = 12,
    parameter int FWID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_gen_run,
    input  logic              wr_fs_run,
    input  logic [DIV_W-1:0]  wr_div,
    input  logic [FPER_W-1:0] wr_fper,
    input  logic [FWID_W-1:0] wr_fwid,
    input  logic              tick,
    output logic              gen_run,
    output logic              fs_run,
    output logic              hw_cause,
    output clk_mode_e         mode,
    output logic [DIV_W-1:0]  act_div,
    output logic [FPER_W-1:0] act_fper,
    output logic [FWID_W-1:0] act_fwid
);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [FPER_W-1:0] fper;
        logic [FWID_W-1:0] fwid;
    } cfg_t;

    typedef struct packed {
        logic gen;
        logic fs;
        logic cause;
        cfg_t shadow;
        cfg_t act;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.gen         = wr_gen_run;
            st_d.fs          = wr_fs_run;
            st_d.shadow.div  = wr_div;
            st_d.shadow.fper = wr_fper;
            st_d.shadow.fwid = wr_fwid;
            if (wr_gen_run) begin
                st_d.cause = 1'b0;
            end
        end
        // settings move to the active copy only on a period boundary,
        // or at any time while the generator is stopped
        if (tick || !st_q.gen) begin
            st_d.act = st_d.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cause <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gen_run  = st_q.gen;
    assign fs_run   = st_q.fs;
    assign hw_cause = st_q.cause;
    assign act_div  = st_q.act.div;
    assign act_fper = st_q.act.fper;
    assign act_fwid = st_q.act.fwid;

    always_comb begin
        if (st_q.gen) begin
            mode = CM_RUN;
        end else if (st_q.cause) begin
            mode = CM_HALF;
        end else begin
            mode = CM_HALT;
        end
    end

endmodule

// File: rtl/srg_divider.sv
module srg_divider
    import srg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  clk_mode_e        mode,
    input  logic [DIV_W-1:0] act_div,
    output logic             tick,
    output logic             div_clk,
    output logic [DIV_W-1:0] cnt
);

    localparam int LEN_W = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             clk;
        logic             fresh;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [LEN_W-1:0] hi_len;

    // high phase length is ceil(N/2) with N = act_div + 1
    assign hi_len = ({1'b0, act_div} + LEN_W'(2)) >> 1;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        unique case (mode)
            CM_RUN: begin
                tick       = st_q.fresh || (st_q.cnt == act_div);
                st_d.cnt   = tick ? '0 : st_q.cnt + DIV_W'(1);
                st_d.clk   = ({1'b0, st_d.cnt} < hi_len);
                st_d.fresh = 1'b0;
            end
            CM_HALF: begin
                st_d.cnt   = '0;
                st_d.clk   = ~st_q.clk;
                st_d.fresh = 1'b1;
            end
            default: begin
                st_d.cnt   = '0;
                st_d.clk   = 1'b0;
                st_d.fresh = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.fresh <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_clk = st_q.clk;
    assign cnt     = st_q.cnt;

endmodule

// File: rtl/srg_frame.sv
module srg_frame #(
    parameter int FPER_W = 12,
    parameter int FWID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [FPER_W-1:0] fper,
    input  logic [FWID_W-1:0] fwid,
    output logic              frame_sync
);

    localparam int CMP_W = (FPER_W > FWID_W) ? FPER_W : FWID_W;

    typedef struct packed {
        logic [FPER_W-1:0] pos;
        logic              started;
        logic              pulse;
    } fr_st_t;

    fr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (tick) begin
            if (!st_q.started || (st_q.pos >= fper)) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + FPER_W'(1);
            end
            st_d.started = 1'b1;
            st_d.pulse   = (CMP_W'(st_d.pos) <= CMP_W'(fwid));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_sync = st_q.pulse;

endmodule

// File: rtl/srg_clkfs_gen.sv
module srg_clkfs_gen
    import srg_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int FPER_W = 12,
    parameter int FWID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_gen_run,
    input  logic              wr_fs_run,
    input  logic [DIV_W-1:0]  wr_div,
    input  logic [FPER_W-1:0] wr_fper,
    input  logic [FWID_W-1:0] wr_fwid,
    output logic              gen_run_rd,
    output logic              fs_run_rd,
    output logic              bit_clk,
    output logic              frame_sync
);

    logic              gen_run_q;
    logic              fs_run_q;
    logic              hw_cause_q;
    clk_mode_e         mode;
    logic [DIV_W-1:0]  act_div;
    logic [FPER_W-1:0] act_fper;
    logic [FWID_W-1:0] act_fwid;
    logic              tick;
    logic              div_clk_q;
    logic [DIV_W-1:0]  div_cnt_q;
    logic              bypass;

    srg_ctrl #(
        .DIV_W (DIV_W),
        .FPER_W(FPER_W),
        .FWID_W(FWID_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_gen_run(wr_gen_run),
        .wr_fs_run (wr_fs_run),
        .wr_div    (wr_div),
        .wr_fper   (wr_fper),
        .wr_fwid   (wr_fwid),
        .tick      (tick),
        .gen_run   (gen_run_q),
        .fs_run    (fs_run_q),
        .hw_cause  (hw_cause_q),
        .mode      (mode),
        .act_div   (act_div),
        .act_fper  (act_fper),
        .act_fwid  (act_fwid)
    );

    srg_divider #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .act_div(act_div),
        .tick   (tick),
        .div_clk(div_clk_q),
        .cnt    (div_cnt_q)
    );

    srg_frame #(
        .FPER_W(FPER_W),
        .FWID_W(FWID_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (gen_run_q && fs_run_q),
        .tick      (tick),
        .fper      (act_fper),
        .fwid      (act_fwid),
        .frame_sync(frame_sync)
    );

    // a divide-by-one setting hands the input clock straight through
    assign bypass     = (mode == CM_RUN) && (act_div == '0);
    assign bit_clk    = bypass ? clk : div_clk_q;
    assign gen_run_rd = gen_run_q;
    assign fs_run_rd  = fs_run_q;

endmodule

// File: rtl/srg_clkfs_gen_chk.sv
module srg_clkfs_gen_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_gen_run,
    input logic             wr_fs_run,
    input logic             gen_run_rd,
    input logic             fs_run_rd,
    input logic             frame_sync,
    input logic             hw_cause,
    input logic             div_clk,
    input logic [DIV_W-1:0] cnt,
    input logic [DIV_W-1:0] act_div
);

    // R2: stopped since hardware reset, the clock path inverts each edge
    assert_half_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_run_rd && hw_cause) |=> (div_clk != $past(div_clk)));

    // R3: run bits follow the accepted write
    assert_readback_gen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (gen_run_rd == $past(wr_gen_run)));
    assert_readback_fs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (fs_run_rd == $past(wr_fs_run)));

    // R4: once software has run the generator, a stop holds the clock low
    assert_cause_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_gen_run) |=> !hw_cause);
    assert_sw_halt_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_run_rd && !hw_cause) |=> !div_clk);

    // R5: the period counter never passes the active divider value
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_div);

    // R8 / R10: no frame pulse while either run bit is clear
    assert_fs_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_run_rd |=> !frame_sync);
    assert_gen_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_run_rd |=> !frame_sync);

endmodule

bind srg_clkfs_gen srg_clkfs_gen_chk #(
    .DIV_W(DIV_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_gen_run(wr_gen_run),
    .wr_fs_run (wr_fs_run),
    .gen_run_rd(gen_run_rd),
    .fs_run_rd (fs_run_rd),
    .frame_sync(frame_sync),
    .hw_cause  (hw_cause_q),
    .div_clk   (div_clk_q),
    .cnt       (div_cnt_q),
    .act_div   (act_div)
);

// File: tb/srg_clkfs_gen_tb.sv
`timescale 1ns/1ps
module srg_clkfs_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_gen_run = 1'b0;
    logic        wr_fs_run = 1'b0;
    logic [7:0]  wr_div = '0;
    logic [11:0] wr_fper = '0;
    logic [7:0]  wr_fwid = '0;
    logic        gen_run_rd, fs_run_rd, bit_clk, frame_sync;

    int   n_chk = 0;
    int   n_err = 0;
    logic hi_clk, lo_clk, hi_fs, lo_fs;

    always #4 clk = ~clk;

    srg_clkfs_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_gen_run(wr_gen_run),
        .wr_fs_run (wr_fs_run),
        .wr_div    (wr_div),
        .wr_fper   (wr_fper),
        .wr_fwid   (wr_fwid),
        .gen_run_rd(gen_run_rd),
        .fs_run_rd (fs_run_rd),
        .bit_clk   (bit_clk),
        .frame_sync(frame_sync)
    );

    task automatic cyc();
        @(posedge clk); #1;
        hi_clk = bit_clk;
        hi_fs  = frame_sync;
        @(negedge clk); #1;
        lo_clk = bit_clk;
        lo_fs  = frame_sync;
    endtask

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic set_wr(input bit g, input bit f, input int d, input int p, input int w);
        wr_gen_run = g;
        wr_fs_run  = f;
        wr_div     = 8'(d);
        wr_fper    = 12'(p);
        wr_fwid    = 8'(w);
        wr_en      = 1'b1;
    endtask

    task automatic wr(input bit g, input bit f, input int d, input int p, input int w);
        set_wr(g, f, d, p, w);
        cyc();
        wr_en = 1'b0;
    endtask

    function automatic int exp_clk(input int k, input int n, input bit hi_phase);
        if (n == 1) return hi_phase ? 1 : 0;
        return ((k % n) < ((n + 1) / 2)) ? 1 : 0;
    endfunction

    function automatic int exp_fs(input int k, input int ks, input int n, input int p, input int w);
        if (ks < 0 || k < ks) return 0;
        return ((((k - ks) / n) % (p + 1)) <= w) ? 1 : 0;
    endfunction

    task automatic chk_halt(input string req, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            cyc();
            chk(req, "halt clk hi", hi_clk, 0);
            chk(req, "halt clk lo", lo_clk, 0);
            chk(req, "halt fs", hi_fs, 0);
        end
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic prev;
        int   ks;
        int   n;
        int   exp_v;
        string tag;

        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R1", "clk", hi_clk, 0);
            chk("R1", "fs", hi_fs, 0);
            chk("R1", "gen_rd", gen_run_rd, 0);
            chk("R1", "fs_rd", fs_run_rd, 0);
        end
        rst_n = 1'b1;

        // R2: half-rate toggling after hardware reset
        for (int i = 1; i <= 8; i++) begin
            cyc();
            chk("R2", "toggle hi", hi_clk, i % 2);
            chk("R2", "toggle lo", lo_clk, i % 2);
            chk("R2", "fs", hi_fs, 0);
        end
        prev = hi_clk;
        wr(1'b0, 1'b1, 1, 2, 0);
        chk("R2", "toggle across stop write", hi_clk, int'(!prev));
        chk("R3", "gen_rd", gen_run_rd, 0);
        chk("R3", "fs_rd", fs_run_rd, 1);
        for (int i = 0; i < 6; i++) begin
            prev = hi_clk;
            cyc();
            chk("R2", "toggle kept", hi_clk, int'(!prev));
            chk("R2", "fs held", hi_fs, 0);
        end

        // R3/R4: run once, then stop: outputs held low
        wr(1'b1, 1'b0, 1, 0, 0);
        chk("R3", "gen_rd", gen_run_rd, 1);
        chk("R3", "fs_rd", fs_run_rd, 0);
        repeat (4) cyc();
        wr(1'b0, 1'b0, 1, 0, 0);
        cyc();
        chk_halt("R4", 6);

        // R5/R6/R7: sweep divider, period and width with both bits enabled together
        for (int d = 0; d <= 4; d++) begin
            for (int p = 0; p <= 3; p++) begin
                for (int w = 0; w <= 3; w++) begin
                    n = d + 1;
                    wr(1'b0, 1'b0, d, p, w);
                    cyc();
                    chk_halt("R4", 1);
                    wr(1'b1, 1'b1, d, p, w);
                    for (int k = 0; k < n * (p + 1) * 2 + 2; k++) begin
                        cyc();
                        chk("R5", $sformatf("clk hi d=%0d k=%0d", d, k), hi_clk, exp_clk(k, n, 1'b1));
                        chk("R5", $sformatf("clk lo d=%0d k=%0d", d, k), lo_clk, exp_clk(k, n, 1'b0));
                        tag = (k < n) ? "R7" : "R6";
                        chk(tag, $sformatf("fs d=%0d p=%0d w=%0d k=%0d", d, p, w, k),
                            hi_fs, exp_fs(k, 0, n, p, w));
                    end
                end
            end
        end

        // R10 / R7 / R8: frame bit enabled late, then disabled
        wr(1'b0, 1'b0, 2, 2, 0);
        cyc();
        wr(1'b1, 1'b0, 2, 2, 0);
        n  = 3;
        ks = -1;
        for (int k = 0; k <= 36; k++) begin
            cyc();
            if (k >= 30)              tag = "R8";
            else if (ks < 0 || k < ks) tag = "R10";
            else if (k < ks + n)       tag = "R7";
            else                       tag = "R6";
            chk(tag, $sformatf("clk k=%0d", k), hi_clk, exp_clk(k, n, 1'b1));
            exp_v = (k >= 30) ? 0 : exp_fs(k, ks, n, 2, 0);
            chk(tag, $sformatf("fs k=%0d", k), hi_fs, exp_v);
            if (k == 5)  chk("R3", "fs_rd on", fs_run_rd, 1);
            if (k == 29) chk("R3", "fs_rd off", fs_run_rd, 0);
            if (k == 4) begin
                set_wr(1'b1, 1'b1, 2, 2, 0);
                ks = (5 / n + 1) * n;
            end
            if (k == 5)  wr_en = 1'b0;
            if (k == 28) set_wr(1'b1, 1'b0, 2, 2, 0);
            if (k == 29) wr_en = 1'b0;
        end

        // R9: divider change while running lands on the next period boundary
        wr(1'b0, 1'b0, 3, 0, 0);
        cyc();
        wr(1'b1, 1'b0, 3, 0, 0);
        for (int k = 0; k <= 20; k++) begin
            cyc();
            exp_v = (k < 8) ? (((k % 4) < 2) ? 1 : 0) : (((k - 8) % 2) < 1 ? 1 : 0);
            chk("R9", $sformatf("clk k=%0d", k), hi_clk, exp_v);
            chk("R9", $sformatf("clk lo k=%0d", k), lo_clk, exp_v);
            if (k == 5) set_wr(1'b1, 1'b0, 1, 0, 0);
            if (k == 6) wr_en = 1'b0;
        end

        // R4: stop from running
        wr(1'b0, 1'b0, 1, 0, 0);
        cyc();
        chk_halt("R4", 5);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule